// File: doc/BRIEF.md
# Radix-4 Early-Exit Sequential Multiplier

This block forms the low `WIDTH` bits of the product of two unsigned (or two's-complement, since only the low half is kept) operands. It spends one cycle capturing the operands, then retires two bits of the second operand per clock. It stops as soon as nothing of that operand remains, so a short second operand costs only a few cycles and a full-width one costs `WIDTH/2` steps. A pair of ones is recoded as minus one with a carry into the next pair. This keeps every partial product to a shift or a negation of the first operand, so no triple multiple is needed.

Operands enter through a valid/ready pair. The caller holds `in_valid` with stable `op_a`/`op_b`, and the transfer happens on the rising edge where `in_ready` is also high. `in_ready` stays low for the whole operation, and any `in_valid` raised in that time is dropped rather than queued. The result side cannot be stalled: `out_valid` pulses for one cycle, and `product` and `cycles` keep their values until the next result replaces them. `cycles` reports the setup cycle plus the number of steps, so a bench or a performance model can check the latency that depends on the data.

Top module: `radix4_early_mul`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state. After that edge `in_ready` is 1, `out_valid` is 0, and `product` and `cycles` are 0.
- R2: `product` equals `(op_a * op_b) mod 2^WIDTH` for the accepted operands.
- R3: Operands are captured on the edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` is 0 until the cycle in which `out_valid` is 1, when it is 1 again.
- R4: `in_valid` while `in_ready` is 0 has no effect. The running result is unchanged, and no second result appears afterwards.
- R5: `out_valid` is high for exactly one cycle per accepted operation. `product` and `cycles` change only in that cycle and hold afterwards.
- R6: Each step consumes the two low bits of the remaining second operand and shifts it right by two. `cycles` = 1 + number of steps. A second operand of 0 gives `cycles` = 1 and `product` = 0.
- R7: A step's digit is the bit pair plus the pending carry. 0 adds nothing, 1 adds the shifted `op_a`, 2 adds twice it, 3 subtracts it and sets the carry, and 4 adds nothing and sets the carry. The operation ends only when the remaining bits and the carry are both zero, so `op_b` = 3 takes 2 steps (`cycles` = 3).
- R8: No operation takes more than `WIDTH/2` steps. A carry out of the top pair is dropped, so an all-ones `op_b` gives `cycles` = `WIDTH/2 + 1` (17 at the default width).
- R9: `op_b` = 160 finishes with `cycles` = 5, and `product` equals `(op_a << 7) + (op_a << 5)` modulo 2^WIDTH.
- R10: `out_valid` rises `cycles + 1` rising edges after the accepting edge, counting the accepting edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are offered |
| in_ready | output | 1 | Block is idle and accepts operands this edge |
| op_a | input | WIDTH | First operand (shifted and added) |
| op_b | input | WIDTH | Second operand (scanned two bits per step) |
| out_valid | output | 1 | One-cycle pulse: `product` and `cycles` are new |
| product | output | WIDTH | Low `WIDTH` bits of the product |
| cycles | output | $clog2(WIDTH/2+2) | Setup cycle plus steps used by the last operation |

## Verification
The bench builds the block with its default `WIDTH` of 32. At that width the full 17-cycle worst case is reachable, and so is the dropped carry out of the top pair (`op_b` with bit pattern 11 at the top). Expected step counts come from a bench-side walk over the digit pairs of the second operand. This covers early exits at every length, the extra step caused by a trailing carry, and the two-bit-set shortcut for 160 as an arithmetic cross-check.

// File: rtl/r4e_pkg.sv
package r4e_pkg;
  typedef enum logic [1:0] {
    PP_NONE   = 2'd0,
    PP_PLUS1  = 2'd1,
    PP_PLUS2  = 2'd2,
    PP_MINUS1 = 2'd3
  } pp_sel_e;
endpackage

// File: rtl/r4e_recoder.sv
module r4e_recoder
  import r4e_pkg::*;
(
  input  logic [1:0] pair,
  input  logic       cin,
  output pp_sel_e    sel,
  output logic       cout
);
  logic [2:0] digit;

  always_comb begin
    digit = {1'b0, pair} + {2'b00, cin};
    sel   = PP_NONE;
    cout  = 1'b0;
    unique case (digit)
      3'd0: begin sel = PP_NONE;   cout = 1'b0; end
      3'd1: begin sel = PP_PLUS1;  cout = 1'b0; end
      3'd2: begin sel = PP_PLUS2;  cout = 1'b0; end
      3'd3: begin sel = PP_MINUS1; cout = 1'b1; end // R7
      3'd4: begin sel = PP_NONE;   cout = 1'b1; end // R7
      default: begin sel = PP_NONE; cout = 1'b0; end
    endcase
  end
endmodule

// File: rtl/r4e_accum.sv
module r4e_accum
  import r4e_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc_in,
  input  logic [WIDTH-1:0] mcand,
  input  pp_sel_e          sel,
  output logic [WIDTH-1:0] acc_out
);
  logic [WIDTH-1:0] addend;

  always_comb begin
    unique case (sel)
      PP_PLUS1:  addend = mcand;
      PP_PLUS2:  addend = mcand << 1;
      PP_MINUS1: addend = ~mcand + WIDTH'(1);
      default:   addend = '0;
    endcase
    acc_out = acc_in + addend;
  end
endmodule

// File: rtl/r4e_datapath.sv
module r4e_datapath
  import r4e_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] acc,
  output logic             rem_zero
);
  logic [WIDTH-1:0] mcand;
  logic [WIDTH-1:0] mplier;
  logic             carry;
  pp_sel_e          sel;
  logic             carry_nxt;
  logic [WIDTH-1:0] acc_nxt;

  r4e_recoder u_rec (
    .pair (mplier[1:0]),
    .cin  (carry),
    .sel  (sel),
    .cout (carry_nxt)
  );

  r4e_accum #(.WIDTH(WIDTH)) u_acc (
    .acc_in  (acc),
    .mcand   (mcand),
    .sel     (sel),
    .acc_out (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      carry  <= 1'b0;
    end else if (load) begin
      acc    <= '0;
      mcand  <= a_in;
      mplier <= b_in;
      carry  <= 1'b0;
    end else if (step) begin
      acc    <= acc_nxt;
      mcand  <= mcand << 2;
      mplier <= mplier >> 2;  // R6
      carry  <= carry_nxt;
    end
  end

  assign rem_zero = (mplier == '0) && !carry;  // R7
endmodule

// File: rtl/r4e_ctrl.sv
module r4e_ctrl #(
  parameter int WIDTH  = 32,
  parameter int HALF   = WIDTH / 2,
  parameter int STEP_W = $clog2(HALF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              rem_zero,
  output logic              busy,
  output logic              load,
  output logic              step,
  output logic              finish,
  output logic              done,
  output logic [STEP_W-1:0] steps
);
  localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(HALF);

  assign load   = in_valid && !busy;                       // R3 R4
  assign finish = busy && (rem_zero || steps == STEP_MAX); // R8
  assign step   = busy && !finish;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      steps <= '0;
    end else begin
      done <= finish;  // R5
      if (load) begin
        busy  <= 1'b1;
        steps <= '0;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (step) begin
        steps <= steps + STEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/radix4_early_mul.sv
module radix4_early_mul #(
  parameter int WIDTH  = 32,
  parameter int HALF   = WIDTH / 2,
  parameter int STEP_W = $clog2(HALF + 1),
  parameter int CNT_W  = $clog2(HALF + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] product,
  output logic [CNT_W-1:0] cycles
);
  logic              busy, load, step, finish, done, rem_zero;
  logic [STEP_W-1:0] steps;
  logic [WIDTH-1:0]  acc;

  r4e_ctrl #(.WIDTH(WIDTH), .HALF(HALF), .STEP_W(STEP_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .rem_zero (rem_zero),
    .busy     (busy),
    .load     (load),
    .step     (step),
    .finish   (finish),
    .done     (done),
    .steps    (steps)
  );

  r4e_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .a_in     (op_a),
    .b_in     (op_b),
    .acc      (acc),
    .rem_zero (rem_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
      cycles  <= '0;
    end else if (finish) begin
      product <= acc;                                // R2
      cycles  <= CNT_W'(steps) + CNT_W'(1);          // R6
    end
  end

  assign in_ready  = !busy;
  assign out_valid = done;
endmodule

// File: rtl/r4e_checker.sv
module r4e_checker #(
  parameter int WIDTH = 32,
  parameter int HALF  = WIDTH / 2,
  parameter int CNT_W = $clog2(HALF + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [WIDTH-1:0] product,
  input logic [CNT_W-1:0] cycles
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R5

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R3

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (in_ready && $past(!in_ready))); // R3

  AST_CYCLES_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (cycles >= CNT_W'(1) && cycles <= CNT_W'(HALF + 1))); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(product) && $stable(cycles))); // R5

  AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && $past(!in_ready) && !out_valid) |=> !in_ready || out_valid); // R4
endmodule

bind radix4_early_mul r4e_checker #(.WIDTH(WIDTH), .HALF(HALF), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .product   (product),
  .cycles    (cycles)
);

// File: tb/radix4_early_mul_test.sv
`timescale 1ns/1ps
module radix4_early_mul_test;
  localparam int WIDTH = 32;
  localparam int HALF  = WIDTH / 2;
  localparam int CNT_W = $clog2(HALF + 2);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [WIDTH-1:0] op_a = '0;
  logic [WIDTH-1:0] op_b = '0;
  logic             out_valid;
  logic [WIDTH-1:0] product;
  logic [CNT_W-1:0] cycles;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  radix4_early_mul #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .product(product), .cycles(cycles)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference for the step count: walk digit pairs with a pending carry.
  function automatic int ref_steps(input logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] r = b;
    int c = 0;
    int s = 0;
    while ((r != 0 || c != 0) && s < HALF) begin
      int d = int'(r[1:0]) + c;
      c = (d >= 3) ? 1 : 0;
      r = r >> 2;
      s++;
    end
    return s;
  endfunction

  task automatic run_op(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                        input string req);
    logic [WIDTH-1:0] exp_p = WIDTH'(a * b);
    int exp_c = 1 + ref_steps(b);
    int n;
    @(negedge clk);
    check(in_ready == 1'b1, "R3", "ready before issue", 64'(in_ready), 64'd1);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    check(in_ready == 1'b0, "R3", "busy after accept", 64'(in_ready), 64'd0);
    while (!out_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(product == exp_p, req, "product", 64'(product), 64'(exp_p));
    check(int'(cycles) == exp_c, req, "cycles", 64'(cycles), 64'(exp_c));
    check(n == exp_c + 1, "R10", "edges to out_valid", 64'(n), 64'(exp_c + 1));
    @(negedge clk);
    check(out_valid == 1'b0, "R5", "out_valid width", 64'(out_valid), 64'd0);
    check(product == exp_p, "R5", "product hold", 64'(product), 64'(exp_p));
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "ready/valid after reset",
          64'({in_ready, out_valid}), 64'b10);
    check(product == '0 && cycles == '0, "R1", "outputs after reset",
          64'(product) | 64'(cycles), 64'd0);
  endtask

  task automatic t_zero();
    run_op(32'h1234_5678, 32'd0, "R6");
    check(cycles == CNT_W'(1), "R6", "zero operand cycles", 64'(cycles), 64'd1);
  endtask

  task automatic t_recode();
    run_op(32'd1000, 32'd3, "R7");
    check(cycles == CNT_W'(3), "R7", "b=3 cycles", 64'(cycles), 64'd3);
    run_op(32'h0000_0F0F, 32'd1, "R7");
    run_op(32'd77, 32'd2, "R7");
    run_op(32'hDEAD_BEEF, 32'h0000_00FF, "R7");
    run_op(32'h1357_9BDF, 32'h0000_0BBB, "R7");
  endtask

  task automatic t_160();
    for (int i = 0; i < 4; i++) begin
      logic [WIDTH-1:0] a = 32'h0001_2345 * (i + 1) + 32'd9;
      logic [WIDTH-1:0] alt = (a << 7) + (a << 5);
      run_op(a, 32'd160, "R9");
      check(product == alt, "R9", "shift-add cross-check", 64'(product), 64'(alt));
      check(cycles == CNT_W'(5), "R9", "cycles for 160", 64'(cycles), 64'd5);
    end
  endtask

  task automatic t_worst();
    run_op(32'h0000_0007, 32'hFFFF_FFFF, "R8");
    check(cycles == CNT_W'(HALF + 1), "R8", "all-ones cycles", 64'(cycles), 64'(HALF + 1));
    run_op(32'hCAFE_F00D, 32'hC000_0000, "R8");
    run_op(32'h8000_0001, 32'h8000_0000, "R8");
    run_op(32'h5555_5555, 32'hAAAA_AAAA, "R2");
  endtask

  task automatic t_mixed();
    logic [WIDTH-1:0] s = 32'h9E37_79B9;
    for (int i = 0; i < 24; i++) begin
      logic [WIDTH-1:0] a, b;
      s = s * 32'd1664525 + 32'd1013904223;
      a = s;
      s = s * 32'd1664525 + 32'd1013904223;
      b = s >> (i % WIDTH);
      run_op(a, b, "R2");
    end
  endtask

  task automatic t_busy_ignore();
    logic [WIDTH-1:0] exp_p = WIDTH'(32'd7 * 32'hFFFF_FFFF);
    int extra = 0;
    @(negedge clk);
    op_a = 32'd7; op_b = 32'hFFFF_FFFF; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    op_a = 32'd9; op_b = 32'd5; in_valid = 1'b1;   // R4 offered while busy
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    check(product == exp_p, "R4", "product unaffected", 64'(product), 64'(exp_p));
    check(cycles == CNT_W'(HALF + 1), "R4", "cycles unaffected", 64'(cycles), 64'(HALF + 1));
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid || !in_ready) extra++;
    end
    check(extra == 0, "R4", "no second result", 64'(extra), 64'd0);
    check(product == exp_p, "R4", "product held", 64'(product), 64'(exp_p));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero();
    t_recode();
    t_160();
    t_worst();
    t_busy_ignore();
    t_mixed();
    run_op(32'hFFFF_FFFF, 32'h0000_0001, "R2");
    run_op(32'hFFFF_FFFF, 32'h0000_0000, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule